// File: doc/BRIEF.md
# Daisy-Chained Interrupt Acknowledge Arbiter

This block arbitrates interrupts for a row of devices that share a single request line into a processor. Each device raises a one-cycle request pulse. Its slice holds that pulse as a pending flag. The pending flags of all slices combine by OR into one interrupt output.

When the processor answers with a rising acknowledge, the acknowledge token enters slice 0 and moves slice by slice toward the last one. The first pending slice it meets keeps the token. That slice is granted, and its pending flag is withdrawn. The granted slice alone places its identity code on the vector bus, where the processor reads it while the acknowledge stays high.

Priority depends only on position in the chain: slice 0 has the highest priority. A low-priority slice can wait without limit while higher slices keep asking. This is intended.

Top module: `irq_daisy_arbiter`

## Requirements
- R1: `irq_out` is 1 in the cycle after a request pulse and stays 1 while any slice has a pending request.
- R2: A pending request stays set, with no further pulse, until that slice is granted. This holds even when higher slices are granted ahead of it.
- R3: On the clock edge that first sees `proc_ack` high, the lowest-index pending slice is granted. At most one bit of `dev_grant` is ever 1.
- R4: A pending slice keeps the acknowledge token. Slices after it are not granted during that acknowledge. A slice that is not pending passes the token on.
- R5: At the grant edge, the pending flag of the granted slice clears. `irq_out` falls if no other slice is pending.
- R6: While slice i holds the grant, `vec_bus` equals VEC_BASE + i. With no grant, `vec_bus` is 0.
- R7: A grant holds while `proc_ack` stays high. It drops on the first edge that sees `proc_ack` low.
- R8: Requests are sampled only at the acknowledge rising edge. A request that arrives in the rising cycle or later does not change the grant of that acknowledge.
- R9: A new request pulse on the slice that is granted in the same cycle sets its pending flag again. The set takes priority over the clear.
- R10: An acknowledge rise with nothing pending grants no slice and leaves `vec_bus` at 0.
- R11: Synchronous active-high `rst` clears all pending flags and all grants.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dev_req | input | N_DEV | Per-slice request pulses, bit 0 is the highest priority |
| proc_ack | input | 1 | Acknowledge level from the processor |
| irq_out | output | 1 | Combined request to the processor |
| dev_grant | output | N_DEV | One-hot grant, one bit per slice |
| vec_bus | output | VEC_W | Identity code of the granted slice, 0 when idle |

## Verification
Two events can land on the same clock edge: the acknowledge rise that samples the chain, and a fresh request pulse. The bench provokes this in two ways.

In the first, a higher-priority slice pulses in the very cycle the acknowledge rises. The bench judges that the grant stays with the lower slice that was already pending, and that the late slice is served on the next acknowledge.

In the second, the slice being granted pulses again in the rise cycle. The bench judges that `irq_out` stays high and that the same slice wins the following acknowledge.

// File: rtl/irq_chain_pkg.sv
package irq_chain_pkg;

    // Identity code that slice idx drives on the vector bus.
    function automatic logic [15:0] slice_code(input logic [15:0] base,
                                               input int unsigned idx);
        return base + 16'(idx);
    endfunction

    // State held by one slice of the chain.
    typedef struct packed {
        logic pend;
        logic grant;
    } slice_state_t;

    // Token passing through one slice on an acknowledge rise.
    typedef struct packed {
        logic take;
        logic pass;
    } token_t;

endpackage

// File: rtl/irq_chain_slice.sv
module irq_chain_slice
    import irq_chain_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic req_in,
    input  logic ack_lvl,
    input  logic ack_rise,
    input  logic tok_in,
    output logic tok_out,
    output logic pend_o,
    output logic grant_o
);

    slice_state_t st_q;
    token_t       tok;

    // Token logic: a pending slice keeps the token, an idle one passes it on.
    always_comb begin
        tok.take = tok_in & st_q.pend;
        tok.pass = tok_in & ~st_q.pend;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            // A new pulse wins over the clear caused by a grant.
            if (req_in)
                st_q.pend <= 1'b1;
            else if (tok.take)
                st_q.pend <= 1'b0;

            if (!ack_lvl)
                st_q.grant <= 1'b0;
            else if (ack_rise)
                st_q.grant <= tok.take;
        end
    end

    assign tok_out = tok.pass;
    assign pend_o  = st_q.pend;
    assign grant_o = st_q.grant;

    // R3: a grant only appears on a slice that was pending
    a_r3_grant_from_pend: assert property (@(posedge clk) disable iff (rst)
        $rose(st_q.grant) |-> $past(st_q.pend));

    // R5: the granted slice withdraws its request unless re-pulsed
    a_r5_pend_dropped: assert property (@(posedge clk) disable iff (rst)
        ($rose(st_q.grant) && !$past(req_in)) |-> !st_q.pend);

    // R7: a low acknowledge releases the grant on the next edge
    a_r7_release: assert property (@(posedge clk) disable iff (rst)
        !ack_lvl |=> !st_q.grant);

endmodule

// File: rtl/irq_vec_drive.sv
module irq_vec_drive
    import irq_chain_pkg::*;
#(
    parameter int unsigned N_DEV    = 4,
    parameter int unsigned VEC_W    = 8,
    parameter logic [15:0] VEC_BASE = 16'h0020
) (
    input  logic [N_DEV-1:0] grant,
    output logic [VEC_W-1:0] vec
);

    logic [VEC_W-1:0] part [N_DEV];

    // Each slice contributes its code only while it holds the grant.
    for (genvar g = 0; g < N_DEV; g++) begin : g_part
        localparam logic [15:0] CODE = slice_code(VEC_BASE, g);
        assign part[g] = grant[g] ? CODE[VEC_W-1:0] : '0;
    end

    always_comb begin
        vec = '0;
        for (int i = 0; i < N_DEV; i++)
            vec = vec | part[i];
    end

endmodule

// File: rtl/irq_daisy_arbiter.sv
module irq_daisy_arbiter
    import irq_chain_pkg::*;
#(
    parameter int unsigned N_DEV    = 4,
    parameter int unsigned VEC_W    = 8,
    parameter logic [15:0] VEC_BASE = 16'h0020
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_DEV-1:0] dev_req,
    input  logic             proc_ack,
    output logic             irq_out,
    output logic [N_DEV-1:0] dev_grant,
    output logic [VEC_W-1:0] vec_bus
);

    localparam int unsigned CHAIN_LEN = N_DEV + 1;

    logic                 ack_d;
    logic                 ack_rise;
    logic [CHAIN_LEN-1:0] token;
    logic [N_DEV-1:0]     pend;

    always_ff @(posedge clk) begin
        if (rst) ack_d <= 1'b0;
        else     ack_d <= proc_ack;
    end

    assign ack_rise = proc_ack & ~ack_d;
    assign token[0] = ack_rise;

    for (genvar g = 0; g < N_DEV; g++) begin : g_slice
        irq_chain_slice u_slice (
            .clk      (clk),
            .rst      (rst),
            .req_in   (dev_req[g]),
            .ack_lvl  (proc_ack),
            .ack_rise (ack_rise),
            .tok_in   (token[g]),
            .tok_out  (token[g+1]),
            .pend_o   (pend[g]),
            .grant_o  (dev_grant[g])
        );
    end

    // Request lines combine by OR.
    assign irq_out = |pend;

    irq_vec_drive #(
        .N_DEV    (N_DEV),
        .VEC_W    (VEC_W),
        .VEC_BASE (VEC_BASE)
    ) u_vec (
        .grant (dev_grant),
        .vec   (vec_bus)
    );

    // R3: never more than one grant
    a_r3_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(dev_grant));

    // R6: an idle bus reads zero
    a_r6_idle_zero: assert property (@(posedge clk) disable iff (rst)
        (dev_grant == '0) |-> (vec_bus == '0));

    // R8: a grant in force does not move to another slice
    a_r8_no_steal: assert property (@(posedge clk) disable iff (rst)
        ((dev_grant != '0) && $past(dev_grant != '0)) |-> $stable(dev_grant));

    // R10: without a rise no new grant appears
    a_r10_grant_needs_rise: assert property (@(posedge clk) disable iff (rst)
        ($past(dev_grant) == '0 && dev_grant != '0) |-> $past(ack_rise));

endmodule

// File: tb/irq_daisy_arbiter_bench.sv
`timescale 1ns/1ps
module irq_daisy_arbiter_bench;

    localparam int N  = 4;
    localparam int VW = 8;
    localparam logic [VW-1:0] BASE = 8'h20;

    typedef struct {
        string        tag;
        logic [N-1:0] grant;
        logic [VW-1:0] vec;
        logic         irq;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst;
    logic [N-1:0]  dev_req;
    logic          proc_ack;
    logic          irq_out;
    logic [N-1:0]  dev_grant;
    logic [VW-1:0] vec_bus;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;
    exp_t q[$];

    always #2 clk = ~clk;

    irq_daisy_arbiter #(.N_DEV(N), .VEC_W(VW), .VEC_BASE(16'h0020)) u_irq_daisy_arbiter (
        .clk(clk), .rst(rst), .dev_req(dev_req), .proc_ack(proc_ack),
        .irq_out(irq_out), .dev_grant(dev_grant), .vec_bus(vec_bus)
    );

    // Monitor: pop each expected item and compare it with the ports.
    initial begin
        forever begin
            wait (q.size() > 0);
            begin
                exp_t e;
                e = q.pop_front();
                n_cmp++;
                if (dev_grant !== e.grant || vec_bus !== e.vec || irq_out !== e.irq) begin
                    n_bad++;
                    $display("FAIL %s: got grant=%b vec=%h irq=%b, expected grant=%b vec=%h irq=%b",
                             e.tag, dev_grant, vec_bus, irq_out, e.grant, e.vec, e.irq);
                end
            end
        end
    end

    // One clock edge; outputs are then settled away from the edge.
    task automatic step();
        @(posedge clk);
        #1;
    endtask

    // Inputs change on the falling edge.
    task automatic drive(input logic [N-1:0] req, input logic ack);
        @(negedge clk);
        dev_req  = req;
        proc_ack = ack;
    endtask

    task automatic expect_out(input string tag, input logic [N-1:0] g,
                              input logic [VW-1:0] v, input logic i);
        exp_t e;
        e.tag = tag; e.grant = g; e.vec = v; e.irq = i;
        q.push_back(e);
        #0.5;
    endtask

    // Watchdog: an expired run counts as one failed check.
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; dev_req = '0; proc_ack = 1'b0;
        step(); step();
        expect_out("R11 reset state", 4'b0000, 8'h00, 1'b0);
        drive('0, 1'b0); rst = 1'b0;
        step();

        // R1: one request pulse on slice 2
        drive(4'b0100, 1'b0); step();
        drive(4'b0000, 1'b0);
        expect_out("R1 irq after pulse", 4'b0000, 8'h00, 1'b1);
        step(); step();
        expect_out("R2 pending sticks", 4'b0000, 8'h00, 1'b1);

        // R3/R5/R6: acknowledge grants slice 2
        drive(4'b0000, 1'b1); step();
        expect_out("R3 R5 R6 grant slice2", 4'b0100, BASE + 8'd2, 1'b0);
        step();
        expect_out("R7 grant held", 4'b0100, BASE + 8'd2, 1'b0);
        drive(4'b0000, 1'b0); step();
        expect_out("R7 R6 release", 4'b0000, 8'h00, 1'b0);

        // R4: slices 1 and 3 pending, slice 1 keeps the token
        drive(4'b1010, 1'b0); step();
        drive(4'b0000, 1'b1); step();
        expect_out("R4 slice1 absorbs", 4'b0010, BASE + 8'd1, 1'b1);
        drive(4'b0000, 1'b0); step();
        expect_out("R2 slice3 still pending", 4'b0000, 8'h00, 1'b1);
        drive(4'b0000, 1'b1); step();
        expect_out("R4 slice3 next", 4'b1000, BASE + 8'd3, 1'b0);
        drive(4'b0000, 1'b0); step();

        // R8: slice 0 pulses in the rise cycle, slice 3 already pending
        drive(4'b1000, 1'b0); step();
        drive(4'b0001, 1'b1); step();
        expect_out("R8 late request no steal", 4'b1000, BASE + 8'd3, 1'b1);
        drive(4'b0000, 1'b1); step();
        expect_out("R8 grant unchanged", 4'b1000, BASE + 8'd3, 1'b1);
        drive(4'b0000, 1'b0); step();
        drive(4'b0000, 1'b1); step();
        expect_out("R8 late slice0 served", 4'b0001, BASE + 8'd0, 1'b0);
        drive(4'b0000, 1'b0); step();

        // R9: slice 2 re-pulses in the cycle it is granted
        drive(4'b0100, 1'b0); step();
        drive(4'b0100, 1'b1); step();
        expect_out("R9 rearm on grant", 4'b0100, BASE + 8'd2, 1'b1);
        drive(4'b0000, 1'b0); step();
        drive(4'b0000, 1'b1); step();
        expect_out("R9 rearmed served", 4'b0100, BASE + 8'd2, 1'b0);
        drive(4'b0000, 1'b0); step();

        // R10: acknowledge with nothing pending
        drive(4'b0000, 1'b1); step();
        expect_out("R10 empty ack", 4'b0000, 8'h00, 1'b0);
        drive(4'b0000, 1'b0); step();

        // R11: reset clears a pending request and a grant
        drive(4'b0010, 1'b0); step();
        drive(4'b0000, 1'b1); step();
        expect_out("R3 grant before reset", 4'b0010, BASE + 8'd1, 1'b0);
        drive(4'b1000, 1'b1); rst = 1'b1; step();
        expect_out("R11 reset mid grant", 4'b0000, 8'h00, 1'b0);
        drive(4'b0000, 1'b0); rst = 1'b0; step();
        expect_out("R11 stays clear", 4'b0000, 8'h00, 1'b0);

        wait (q.size() == 0);
        #1;
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule